// File: doc/BRIEF.md
# Scatter-Gather Segment Tracker

This block follows the current scatter-gather segment of a disconnectable data transfer. It keeps a working set of registers: a host-memory pointer to the current segment descriptor, the working address and remaining byte count taken from that descriptor, and a flag that marks the descriptor as already fetched. It also keeps a second, saved set of the same registers. Before each data phase the sequencer pulses a start strobe. If the segment is not yet fetched, the tracker asks the memory side for the descriptor at the pointer. It then either clears the transfer to begin, or refuses and raises a help code when the descriptor marks an overrun.

When a data phase ends, the tracker takes one of two paths. If the DMA engine reports the segment complete, the pointer steps to the next descriptor and the fetched flag is cleared. If the phase ends early, the working address and count take the residual values that the engine reports, and the segment stays current. Save and restore strobes copy the working set to the saved set, or the saved set back to the working set. A command-completion strobe acts as a save. Loading a new command writes both sets from the command's stored state.

Top module: `sg_seg_tracker`

## Requirements
- R1: After reset, the following outputs are zero: the working pointer, working address, working count, fetched flag, fetch request, go pulse, help valid, help code and clash.
- R2: A start pulse while the fetched flag is set issues no fetch request. `xfer_go` is high for exactly the one cycle after the start.
- R3: A start pulse while the fetched flag is clear raises `fetch_req` from the next cycle, with `fetch_addr` equal to the working pointer. Both hold until `fetch_valid`. The descriptor layout is: bits [31:0] address, bits [55:32] count, bits [63:56] flags. On a response without overrun, the working address and count take the descriptor fields, the fetched flag is set, and `xfer_go` pulses for one cycle.
- R4: A response whose flag bit 0 (entry bit 56) is set gives a one-cycle `help_valid` with `help_code` 0x02. There is no go pulse, and the working address, count and fetched flag are unchanged.
- R5: An end-of-transfer with `dma_done` high adds the entry size (8) to the working pointer, modulo 2^32, with the carry rippling across all pointer bytes. It also clears the fetched flag.
- R6: An end-of-transfer with `dma_done` low replaces the working address and count with `res_addr` and `res_cnt`. The pointer and the fetched flag are unchanged.
- R7: `save_req` or `cmd_done` copies the working set (pointer, address, count, fetched flag) to the saved set in one cycle. `restore_req` copies the saved set to the working set in one cycle.
- R8: A save, command-completion or restore strobe is rejected (no copy in either direction) in two cases: when it coincides with an end-of-transfer, and when a save and a restore coincide. A rejection sets `clash`, which stays set until the next command load. The end-of-transfer update still applies.
- R9: `load_cmd` writes both the working and the saved set from the load inputs, clears `clash`, and cancels any fetch in progress. It takes priority over every other strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_cmd | input | 1 | Load a new command's segment state |
| load_ptr | input | 32 | Descriptor pointer to load |
| load_addr | input | 32 | Working address to load |
| load_cnt | input | 24 | Working count to load |
| load_loaded | input | 1 | Fetched flag to load |
| phase_start | input | 1 | A data phase is about to begin |
| fetch_req | output | 1 | Descriptor fetch request |
| fetch_addr | output | 32 | Host address of the descriptor |
| fetch_valid | input | 1 | Descriptor response strobe |
| fetch_data | input | 64 | Descriptor: flags, count, address |
| xfer_end | input | 1 | A data phase has ended |
| dma_done | input | 1 | The segment was fully transferred |
| res_addr | input | 32 | Residual host address from the DMA engine |
| res_cnt | input | 24 | Residual count from the DMA engine |
| save_req | input | 1 | Copy the working set to the saved set |
| cmd_done | input | 1 | Command completion; acts as a save |
| restore_req | input | 1 | Copy the saved set to the working set |
| xfer_go | output | 1 | One-cycle pulse: the transfer may begin |
| help_valid | output | 1 | One-cycle pulse: help needed |
| help_code | output | 8 | Help reason, 0x02 for overrun |
| clash | output | 1 | Sticky: a copy strobe was rejected |
| work_ptr | output | 32 | Working descriptor pointer |
| work_addr | output | 32 | Working address |
| work_cnt | output | 24 | Working remaining count |
| work_loaded | output | 1 | Working fetched flag |

## Verification
The end-of-transfer update can land in the same cycle as a save, command-completion or restore strobe. Both are register writes to the same sets, so only one can win. The bench drives an end-of-transfer together with a restore, and separately together with a command completion. It then checks three things: the working set shows the end-of-transfer result, `clash` is set, and a later restore on its own returns the saved set from before the collision. That last check proves the rejected strobe moved nothing.

// File: rtl/sg_pkg.sv
package sg_pkg;
   typedef enum logic [0:0] {FS_IDLE = 1'b0, FS_WAIT = 1'b1} fetch_st_t;
   localparam logic [7:0] HELP_NONE    = 8'h00;
   localparam logic [7:0] HELP_OVERRUN = 8'h02;
endpackage

// File: rtl/sg_ptr_step.sv
module sg_ptr_step #(
   parameter int PTR_W       = 32,
   parameter int ENTRY_BYTES = 8,
   parameter bit BYTEWISE    = 1'b1
) (
   input  logic [PTR_W-1:0] ptr_in,
   output logic [PTR_W-1:0] ptr_out
);
   localparam logic [PTR_W-1:0] STEP = PTR_W'(ENTRY_BYTES);
   localparam int NBYTES = PTR_W / 8;

   if (ENTRY_BYTES < 1) begin : g_bad_step
      $error("sg_ptr_step: ENTRY_BYTES must be positive");
   end

   if (BYTEWISE) begin : g_ripple
      if (PTR_W % 8 != 0) begin : g_bad_w
         $error("sg_ptr_step: PTR_W must be a byte multiple");
      end
      logic [NBYTES:0] carry;
      assign carry[0] = 1'b0;
      for (genvar i = 0; i < NBYTES; i++) begin : g_byte
         logic [8:0] sum;
         assign sum = {1'b0, ptr_in[8*i +: 8]} + {1'b0, STEP[8*i +: 8]} + {8'd0, carry[i]};
         assign ptr_out[8*i +: 8] = sum[7:0];
         assign carry[i+1] = sum[8];
      end
   end else begin : g_flat
      assign ptr_out = ptr_in + STEP;
   end
endmodule

// File: rtl/sg_shadow.sv
module sg_shadow #(
   parameter int W = 89
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_val,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("sg_shadow: W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (wr_en) q <= wr_val;
   end
endmodule

// File: rtl/sg_fetch_fsm.sv
module sg_fetch_fsm
   import sg_pkg::*;
#(
   parameter int PTR_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cancel,
   input  logic             start,
   input  logic             loaded,
   input  logic [PTR_W-1:0] ptr,
   input  logic             rsp_valid,
   input  logic             rsp_overrun,
   output logic             req,
   output logic [PTR_W-1:0] req_addr,
   output logic             take,
   output logic             go,
   output logic             help,
   output logic [7:0]       code
);
   fetch_st_t st;

   assign req  = (st == FS_WAIT);
   assign take = req && rsp_valid && !rsp_overrun && !cancel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= FS_IDLE;
         req_addr <= '0;
         go       <= 1'b0;
         help     <= 1'b0;
         code     <= HELP_NONE;
      end else begin
         go   <= 1'b0;
         help <= 1'b0;
         code <= HELP_NONE;
         if (cancel) begin
            st <= FS_IDLE;
         end else begin
            case (st)
               FS_IDLE: if (start) begin
                  if (loaded) go <= 1'b1;
                  else begin
                     st       <= FS_WAIT;
                     req_addr <= ptr;
                  end
               end
               FS_WAIT: if (rsp_valid) begin
                  st <= FS_IDLE;
                  if (rsp_overrun) begin
                     help <= 1'b1;
                     code <= HELP_OVERRUN;
                  end else begin
                     go <= 1'b1;
                  end
               end
               default: st <= FS_IDLE;
            endcase
         end
      end
   end

   AST_HELP_NO_GO: assert property (@(posedge clk) disable iff (!rst_n)
      help |-> !go); // R4
   AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      req && !rsp_valid && !cancel |=> req && $stable(req_addr)); // R3
   AST_LOADED_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      !req && start && loaded && !cancel |=> go && !req); // R2
endmodule

// File: rtl/sg_seg_tracker.sv
module sg_seg_tracker
   import sg_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int CNT_W       = 24,
   parameter int FLAG_W      = 8,
   parameter int PTR_W       = 32,
   parameter int ENTRY_BYTES = 8,
   parameter int OVR_BIT     = 0,
   parameter bit BYTEWISE    = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          load_cmd,
   input  logic [PTR_W-1:0]              load_ptr,
   input  logic [ADDR_W-1:0]             load_addr,
   input  logic [CNT_W-1:0]              load_cnt,
   input  logic                          load_loaded,
   input  logic                          phase_start,
   output logic                          fetch_req,
   output logic [PTR_W-1:0]              fetch_addr,
   input  logic                          fetch_valid,
   input  logic [ADDR_W+CNT_W+FLAG_W-1:0] fetch_data,
   input  logic                          xfer_end,
   input  logic                          dma_done,
   input  logic [ADDR_W-1:0]             res_addr,
   input  logic [CNT_W-1:0]              res_cnt,
   input  logic                          save_req,
   input  logic                          cmd_done,
   input  logic                          restore_req,
   output logic                          xfer_go,
   output logic                          help_valid,
   output logic [7:0]                    help_code,
   output logic                          clash,
   output logic [PTR_W-1:0]              work_ptr,
   output logic [ADDR_W-1:0]             work_addr,
   output logic [CNT_W-1:0]              work_cnt,
   output logic                          work_loaded
);
   localparam int ST_W   = PTR_W + ADDR_W + CNT_W + 1;
   localparam int CNT_LO = ADDR_W;
   localparam int FLG_LO = ADDR_W + CNT_W;

   if (OVR_BIT < 0 || OVR_BIT >= FLAG_W) begin : g_bad_ovr
      $error("sg_seg_tracker: OVR_BIT outside the flag field");
   end
   if (ENTRY_BYTES * 8 < ADDR_W + CNT_W + FLAG_W) begin : g_bad_entry
      $error("sg_seg_tracker: ENTRY_BYTES too small for the descriptor");
   end

   logic             take;
   logic [PTR_W-1:0] ptr_next;
   logic [ST_W-1:0]  saved_q;
   logic [ST_W-1:0]  work_vec;
   logic             want_save, collide, save_ok, restore_ok;

   assign work_vec   = {work_ptr, work_addr, work_cnt, work_loaded};
   assign want_save  = save_req || cmd_done;
   assign collide    = (xfer_end && (want_save || restore_req)) || (want_save && restore_req);
   assign save_ok    = want_save && !collide && !load_cmd;
   assign restore_ok = restore_req && !collide && !load_cmd;

   sg_fetch_fsm #(.PTR_W(PTR_W)) u_fetch (
      .clk(clk), .rst_n(rst_n), .cancel(load_cmd), .start(phase_start),
      .loaded(work_loaded), .ptr(work_ptr), .rsp_valid(fetch_valid),
      .rsp_overrun(fetch_data[FLG_LO + OVR_BIT]), .req(fetch_req),
      .req_addr(fetch_addr), .take(take), .go(xfer_go), .help(help_valid),
      .code(help_code)
   );

   sg_ptr_step #(.PTR_W(PTR_W), .ENTRY_BYTES(ENTRY_BYTES), .BYTEWISE(BYTEWISE)) u_step (
      .ptr_in(work_ptr), .ptr_out(ptr_next)
   );

   sg_shadow #(.W(ST_W)) u_saved (
      .clk(clk), .rst_n(rst_n), .wr_en(load_cmd || save_ok),
      .wr_val(load_cmd ? {load_ptr, load_addr, load_cnt, load_loaded} : work_vec),
      .q(saved_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         work_ptr    <= '0;
         work_addr   <= '0;
         work_cnt    <= '0;
         work_loaded <= 1'b0;
         clash       <= 1'b0;
      end else if (load_cmd) begin
         work_ptr    <= load_ptr;
         work_addr   <= load_addr;
         work_cnt    <= load_cnt;
         work_loaded <= load_loaded;
         clash       <= 1'b0;
      end else begin
         if (collide) clash <= 1'b1;
         if (xfer_end) begin
            if (dma_done) begin
               work_ptr    <= ptr_next;
               work_loaded <= 1'b0;
            end else begin
               work_addr <= res_addr;
               work_cnt  <= res_cnt;
            end
         end else if (restore_ok) begin
            {work_ptr, work_addr, work_cnt, work_loaded} <= saved_q;
         end
         if (take) begin
            work_addr   <= fetch_data[ADDR_W-1:0];
            work_cnt    <= fetch_data[CNT_LO +: CNT_W];
            work_loaded <= 1'b1;
         end
      end
   end

   AST_DONE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_end && dma_done && !load_cmd |=> work_ptr == $past(work_ptr) + PTR_W'(ENTRY_BYTES)); // R5
   AST_RESIDUAL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_end && !dma_done && !load_cmd && !take |=> work_addr == $past(res_addr) && work_cnt == $past(res_cnt)); // R6
   AST_CLASH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      clash && !load_cmd |=> clash); // R8
   AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      load_cmd |=> !clash && !fetch_req && work_ptr == $past(load_ptr)); // R9
endmodule

// File: tb/sim_sg_seg_tracker.sv
module sim_sg_seg_tracker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_cmd = 0, load_loaded = 0, phase_start = 0, fetch_valid = 0;
   logic        xfer_end = 0, dma_done = 0, save_req = 0, cmd_done = 0, restore_req = 0;
   logic [31:0] load_ptr = 0, load_addr = 0, res_addr = 0;
   logic [23:0] load_cnt = 0, res_cnt = 0;
   logic [63:0] fetch_data = 0;
   logic        fetch_req, xfer_go, help_valid, clash, work_loaded;
   logic [31:0] fetch_addr, work_ptr, work_addr;
   logic [23:0] work_cnt;
   logic [7:0]  help_code;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   typedef struct packed { logic is_help; logic [31:0] addr; } exp_t;
   exp_t exp_q[$];

   always #10 clk = ~clk;

   sg_seg_tracker u0 (
      .clk(clk), .rst_n(rst_n), .load_cmd(load_cmd), .load_ptr(load_ptr),
      .load_addr(load_addr), .load_cnt(load_cnt), .load_loaded(load_loaded),
      .phase_start(phase_start), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
      .fetch_valid(fetch_valid), .fetch_data(fetch_data), .xfer_end(xfer_end),
      .dma_done(dma_done), .res_addr(res_addr), .res_cnt(res_cnt),
      .save_req(save_req), .cmd_done(cmd_done), .restore_req(restore_req),
      .xfer_go(xfer_go), .help_valid(help_valid), .help_code(help_code),
      .clash(clash), .work_ptr(work_ptr), .work_addr(work_addr),
      .work_cnt(work_cnt), .work_loaded(work_loaded)
   );

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: every go or help pulse is matched against the scoreboard
   always @(negedge clk) begin
      if (rst_n && (xfer_go || help_valid)) begin
         if (exp_q.size() == 0) begin
            check("R2/R3/R4 unexpected pulse", {62'd0, xfer_go, help_valid}, 64'd0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            if (e.is_help) begin
               check("R4 help pulse", {xfer_go, help_valid, help_code}, {2'b01, 8'h02});
            end else begin
               check("R2/R3 go pulse", {xfer_go, help_valid}, 2'b10);
               check("R3 go address", work_addr, e.addr);
            end
         end
      end
   end

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic clear_strobes();
      load_cmd = 0; phase_start = 0; fetch_valid = 0; xfer_end = 0;
      dma_done = 0; save_req = 0; cmd_done = 0; restore_req = 0;
   endtask

   task automatic do_load(logic [31:0] p, logic [31:0] a, logic [23:0] c, logic l);
      load_cmd = 1; load_ptr = p; load_addr = a; load_cnt = c; load_loaded = l;
      tick(); clear_strobes();
   endtask

   task automatic do_start(); phase_start = 1; tick(); clear_strobes(); endtask

   task automatic do_resp(logic [7:0] f, logic [23:0] c, logic [31:0] a);
      fetch_valid = 1; fetch_data = {f, c, a};
      tick(); clear_strobes();
   endtask

   task automatic do_end(logic d, logic [31:0] ra, logic [23:0] rc, logic sv, logic cd, logic rs);
      xfer_end = 1; dma_done = d; res_addr = ra; res_cnt = rc;
      save_req = sv; cmd_done = cd; restore_req = rs;
      tick(); clear_strobes();
   endtask

   task automatic do_copy(logic sv, logic cd, logic rs);
      save_req = sv; cmd_done = cd; restore_req = rs;
      tick(); clear_strobes();
   endtask

   initial begin
      tick(); tick();
      // R1 reset state
      check("R1 reset outputs",
            {work_ptr, work_addr[7:0], work_cnt[7:0], work_loaded, fetch_req, xfer_go, help_valid, help_code[3:0], clash},
            64'd0);
      rst_n = 1; tick();

      // R9 load sets working set
      do_load(32'h0000_FFF8, 32'h0000_1000, 24'h40, 0);
      check("R9 load ptr", work_ptr, 32'h0000_FFF8);
      check("R9 load addr/cnt", {work_addr, work_cnt}, {32'h1000, 24'h40});

      // R3 fetch when not loaded
      do_start();
      check("R3 fetch request", {fetch_req, fetch_addr}, {1'b1, 32'h0000_FFF8});
      tick(); tick();
      check("R3 request held", {fetch_req, fetch_addr}, {1'b1, 32'h0000_FFF8});
      exp_q.push_back('{1'b0, 32'hA000_0000});
      do_resp(8'h00, 24'h000200, 32'hA000_0000);
      check("R3 entry loaded", {work_addr, work_cnt, work_loaded}, {32'hA000_0000, 24'h200, 1'b1});
      check("R3 request dropped", fetch_req, 0);

      // R2 already loaded: no fetch
      exp_q.push_back('{1'b0, 32'hA000_0000});
      do_start();
      check("R2 no fetch", fetch_req, 0);
      tick();

      // R6 partial transfer keeps entry
      do_end(0, 32'hA000_0080, 24'h180, 0, 0, 0);
      check("R6 residual", {work_addr, work_cnt}, {32'hA000_0080, 24'h180});
      check("R6 ptr/flag kept", {work_ptr, work_loaded}, {32'h0000_FFF8, 1'b1});

      // R7 save then R5 advance then R7 restore
      do_copy(1, 0, 0);
      do_end(1, 32'h0, 24'h0, 0, 0, 0);
      check("R5 advance with carry", {work_ptr, work_loaded}, {32'h0001_0000, 1'b0});
      do_copy(0, 0, 1);
      check("R7 restore", {work_ptr, work_addr, work_cnt, work_loaded},
            {32'h0000_FFF8, 32'hA000_0080, 24'h180, 1'b1});
      check("R8 clash clear so far", clash, 0);

      // R8 restore colliding with end-of-transfer
      do_end(1, 32'h0, 24'h0, 0, 0, 1);
      check("R8 end wins over restore", {work_ptr, work_loaded, clash}, {32'h0001_0000, 1'b0, 1'b1});
      // R8 command completion colliding: saved set must stay untouched
      do_end(0, 32'h0000_000B, 24'h5, 0, 1, 0);
      check("R8 end applied", {work_addr, work_cnt}, {32'hB, 24'h5});
      do_copy(0, 0, 1);
      check("R8 saved untouched", {work_ptr, work_addr, work_cnt},
            {32'h0000_FFF8, 32'hA000_0080, 24'h180});
      check("R8 clash sticky", clash, 1);
      // R8 save and restore together
      do_copy(1, 0, 1);
      check("R8 save+restore rejected", {work_addr, clash}, {32'hA000_0080, 1'b1});

      // R7 command completion acts as save
      do_end(0, 32'h0000_0C00, 24'h9, 0, 0, 0);
      do_copy(0, 1, 0);
      do_end(0, 32'h0, 24'h0, 0, 0, 0);
      do_copy(0, 0, 1);
      check("R7 cmd_done saves", {work_addr, work_cnt}, {32'h0C00, 24'h9});

      // R4 overrun, R9 clash cleared by load
      do_load(32'h0000_2000, 32'h0000_0444, 24'h11, 0);
      check("R9 clash cleared", clash, 0);
      do_start();
      exp_q.push_back('{1'b1, 32'h0});
      do_resp(8'h01, 24'h7, 32'h5555_0000);
      check("R4 state unchanged", {work_addr, work_cnt, work_loaded}, {32'h0444, 24'h11, 1'b0});

      // R5 wraparound
      do_load(32'hFFFF_FFF8, 32'h0, 24'h0, 1);
      do_end(1, 32'h0, 24'h0, 0, 0, 0);
      check("R5 wraparound", {work_ptr, work_loaded}, {32'h0, 1'b0});

      // R9 load cancels fetch
      do_start();
      check("R9 fetch pending", fetch_req, 1);
      do_load(32'h0000_3000, 32'h0, 24'h0, 0);
      check("R9 fetch cancelled", fetch_req, 0);
      fetch_valid = 1; fetch_data = 64'h0; tick(); clear_strobes(); tick();

      check("R2/R3/R4 scoreboard drained", exp_q.size(), 0);
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      #2_000_000;
      if (!finished) begin
         finished = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule